// File: doc/BRIEF.md
# Nested Priority Event Arbiter

This block decides which of sixteen core events should be serviced next. Each event line feeds a latch bit. A mask register and a global enable for the general-purpose levels decide which latched events are eligible. A pending register records every level that is active or nested beneath the current one. The block raises a service request, together with the index of the winning level, only when that level outranks every level that is already pending. Level 0 has the highest priority and level 15 the lowest.

The levels, from highest priority, are: emulation (0), reset (1), non-maskable interrupt (2), exception (3), an unused slot (4), hardware error (5), core timer (6), and general-purpose levels 7 to 15. The core pulses an accept strobe to take a request. That strobe moves the level from latched to pending. A return strobe retires the innermost pending level. Software reaches the latch, mask and pending registers through a small select/write/read port. A supervisor qualifier gates access to the mask and pending registers.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the latch, mask and pending registers read 0, `svc_req` is 0 and the general-purpose enable is on.
- R2: A 1 on `evt_in[i]` in a cycle makes latch bit i read 1 from the next cycle. Level 4 never latches and never requests.
- R3: Among the latched and enabled levels, `svc_idx` names the lowest-numbered one.
- R4: Levels 0, 1, 2, 3 and 5 are serviceable whenever they are latched, whatever the mask and the global enable say. Levels 6 to 15 need their mask bit at 1. With the mask bit at 0 the event stays latched but is not requested.
- R5: A `gp_dis` pulse blocks levels 7 to 15 from requesting, and a `gp_ena` pulse allows them again. If both pulse in the same cycle, disable wins. Level 6 is not affected by the global enable.
- R6: `svc_req` is 1 only when the winning index is strictly lower than the lowest-numbered set pending bit, or when no pending bit is set.
- R7: `svc_ack` while `svc_req` is 1 clears the latch bit and sets the pending bit of level `svc_idx` from the next cycle. `svc_ack` while `svc_req` is 0 has no effect.
- R8: A `svc_ret` pulse clears the lowest-numbered set pending bit.
- R9: A latch write (`reg_sel`=0) changes only the bits whose mask bit is 0. Bits whose mask bit is 1 keep their value.
- R10: A mask write (`reg_sel`=1) takes effect only when `sup_mode` is 1. Mask and pending reads (`reg_sel`=1, 2) return 0 when `sup_mode` is 0. Latch reads are always allowed. `reg_sel`=3 reads 0.
- R11: Register writes never change the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 16 | Event capture lines, one per level |
| gp_ena | input | 1 | Pulse: enable general-purpose levels |
| gp_dis | input | 1 | Pulse: disable general-purpose levels |
| svc_ack | input | 1 | Core accepts the current request |
| svc_ret | input | 1 | Core returns from the innermost event |
| sup_mode | input | 1 | Access is made in supervisor mode |
| reg_sel | input | 2 | 0 latch, 1 mask, 2 pending, 3 none |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| svc_req | output | 1 | A level outranks everything pending |
| svc_idx | output | 4 | Index of the requesting level |

## Verification
The hardest state to reach is one where several levels are nested at once while a lower-priority event waits in the latch. Only that state shows that the request is held back by the innermost pending level, and that each return retires exactly one level. The stimulus first accepts the core timer. It then latches a general-purpose level that must wait, and injects a non-maskable interrupt on top, which is accepted as well. Two returns then unwind the pending levels one at a time. The waiting level must appear only after the second return.

// File: rtl/evt_nest_pkg.sv
// Shared constants for the nested event arbiter.
// Assumes level 0 is the highest priority and that the level roles are fixed.
package evt_nest_pkg;
    localparam int NLVL     = 16;
    localparam int IDXW     = $clog2(NLVL);
    localparam int RSV_LVL  = 4;
    localparam int TMR_LVL  = 6;
    localparam int GP_FIRST = 7;

    typedef enum logic [1:0] {
        SEL_LATCH = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_PEND  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/evt_prio_enc.sv
// Finds the lowest-numbered set bit of a vector.
// Assumes bit 0 is the highest priority. idx is 0 when nothing is set.
module evt_prio_enc #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/evt_latch_bank.sv
// Latch and mask registers for the event levels.
// A latch bit is set by its event line and cleared by a grant. A software
// write reaches only the bits whose mask bit is 0. The reserved level is held at 0.
// Assumes the mask write has already been qualified by the caller.
module evt_latch_bank #(
    parameter int N   = 16,
    parameter int W   = $clog2(N),
    parameter int RSV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_in,
    input  logic         lat_we,
    input  logic         mask_we,
    input  logic [N-1:0] wdata,
    input  logic         clr_en,
    input  logic [W-1:0] clr_idx,
    output logic [N-1:0] lat_q,
    output logic [N-1:0] mask_q
);
    localparam logic [N-1:0] RSV_BIT = N'(1) << RSV;

    logic [N-1:0] lat_d;

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (g == RSV) begin : g_rsv
            assign lat_d[g] = 1'b0;
        end else begin : g_lvl
            logic sw_val;
            assign sw_val   = (lat_we && !mask_q[g]) ? wdata[g] : lat_q[g];
            assign lat_d[g] = (sw_val && !(clr_en && clr_idx == W'(g))) || evt_in[g];
        end
    end

    // Latch register update.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // A captured event is visible in the latch one cycle later.
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_in & ~RSV_BIT) != '0) |=> (($past(evt_in) & ~RSV_BIT & ~lat_q) == '0));

    // A latch write leaves the bits whose mask bit is 1 untouched.
    assert_locked_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_we && !clr_en && evt_in == '0) |=>
        ((lat_q & $past(mask_q)) == ($past(lat_q) & $past(mask_q))));
endmodule

// File: rtl/evt_pend_track.sv
// Pending register that tracks the nested active levels.
// A grant sets one bit. A return clears the lowest-numbered set bit.
// Assumes a grant always names a level above the current innermost one.
module evt_pend_track #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [W-1:0] set_idx,
    input  logic         ret_en,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] lowest;
    logic [N-1:0] set_vec;
    logic [N-1:0] pend_d;

    // Isolate the innermost bit, decode the grant and form the next value.
    always_comb begin
        lowest  = pend_q & (~pend_q + N'(1));
        set_vec = set_en ? (N'(1) << set_idx) : '0;
        pend_d  = (ret_en ? (pend_q & ~lowest) : pend_q) | set_vec;
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // A return without a grant removes exactly one level.
    assert_ret_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !set_en && pend_q != '0) |=>
        ($countones(pend_q) == $countones($past(pend_q)) - 1));

    // Without a grant or a return the register holds.
    assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !ret_en) |=> $stable(pend_q));
endmodule

// File: rtl/evt_nest_ctrl.sv
// Nested priority event arbiter: latches 16 event levels, applies the mask
// and the global enable for the general-purpose levels, and requests service
// for the best level that outranks everything pending.
// Assumes the core pulses svc_ack only to take the request shown in the same cycle.
module evt_nest_ctrl
    import evt_nest_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] evt_in,
    input  logic            gp_ena,
    input  logic            gp_dis,
    input  logic            svc_ack,
    input  logic            svc_ret,
    input  logic            sup_mode,
    input  logic [1:0]      reg_sel,
    input  logic            reg_we,
    input  logic [NLVL-1:0] reg_wdata,
    output logic [NLVL-1:0] reg_rdata,
    output logic            svc_req,
    output logic [IDXW-1:0] svc_idx
);
    logic [NLVL-1:0] lat_q, mask_q, pend_q, en_vec, elig;
    logic            gp_en_q;
    logic            win_found, pend_found, grant;
    logic [IDXW-1:0] win_idx, pend_idx;
    logic            lat_we, mask_we;

    // Global enable for the general-purpose levels. Disable wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)      gp_en_q <= 1'b1;
        else if (gp_dis) gp_en_q <= 1'b0;
        else if (gp_ena) gp_en_q <= 1'b1;
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_en
        if (g == RSV_LVL) begin : g_rsv
            assign en_vec[g] = 1'b0;
        end else if (g < TMR_LVL) begin : g_fixed
            assign en_vec[g] = 1'b1;
        end else if (g < GP_FIRST) begin : g_tmr
            assign en_vec[g] = mask_q[g];
        end else begin : g_gp
            assign en_vec[g] = mask_q[g] && gp_en_q;
        end
    end

    assign elig = lat_q & en_vec;

    evt_prio_enc #(.N(NLVL), .W(IDXW)) u_win_enc (
        .vec(elig), .found(win_found), .idx(win_idx)
    );

    evt_prio_enc #(.N(NLVL), .W(IDXW)) u_pend_enc (
        .vec(pend_q), .found(pend_found), .idx(pend_idx)
    );

    // Request only when the winner outranks the innermost pending level.
    always_comb begin
        svc_req = win_found && (!pend_found || (win_idx < pend_idx));
        svc_idx = win_idx;
        grant   = svc_req && svc_ack;
        lat_we  = reg_we && (reg_sel == SEL_LATCH);
        mask_we = reg_we && (reg_sel == SEL_MASK) && sup_mode;
    end

    evt_latch_bank #(.N(NLVL), .W(IDXW), .RSV(RSV_LVL)) u_latch (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .lat_we(lat_we), .mask_we(mask_we), .wdata(reg_wdata),
        .clr_en(grant), .clr_idx(win_idx),
        .lat_q(lat_q), .mask_q(mask_q)
    );

    evt_pend_track #(.N(NLVL), .W(IDXW)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(grant), .set_idx(win_idx), .ret_en(svc_ret),
        .pend_q(pend_q)
    );

    // Register read mux with supervisor qualification.
    always_comb begin
        case (reg_sel)
            SEL_LATCH: reg_rdata = lat_q;
            SEL_MASK:  reg_rdata = sup_mode ? mask_q : '0;
            SEL_PEND:  reg_rdata = sup_mode ? pend_q : '0;
            default:   reg_rdata = '0;
        endcase
    end

    logic [NLVL:0] upto_mask;
    assign upto_mask = ((NLVL+1)'(1) << (svc_idx + 1'b1)) - (NLVL+1)'(1);

    // A request never coexists with a pending level at or above its priority.
    assert_nest_rank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (({1'b0, pend_q} & upto_mask) == '0));

    // An accepted level is pending in the next cycle.
    assert_ack_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> pend_q[$past(win_idx)]);

    // A mask write outside supervisor mode changes nothing.
    assert_mask_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_MASK && !sup_mode) |=> $stable(mask_q));

    // General-purpose levels request only while globally enabled.
    assert_gp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && svc_idx >= IDXW'(GP_FIRST)) |-> gp_en_q);

    // The reserved slot never requests.
    assert_rsv_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (svc_idx != IDXW'(RSV_LVL)));
endmodule

// File: tb/test_evt_nest_ctrl.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares at negedge.
module test_evt_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_in = '0;
    logic        gp_ena = 1'b0, gp_dis = 1'b0, svc_ack = 1'b0, svc_ret = 1'b0;
    logic        sup_mode = 1'b1;
    logic [1:0]  reg_sel = 2'd3;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        svc_req;
    logic [3:0]  svc_idx;

    typedef struct {
        int          cyc;
        bit          is_reg;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    evt_nest_ctrl i_evt_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .gp_ena(gp_ena), .gp_dis(gp_dis),
        .svc_ack(svc_ack), .svc_ret(svc_ret), .sup_mode(sup_mode), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .svc_req(svc_req), .svc_idx(svc_idx)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = it.is_reg ? reg_rdata : {11'd0, svc_req, svc_idx};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        evt_in = '0; gp_ena = 0; gp_dis = 0; svc_ack = 0; svc_ret = 0;
        reg_we = 0; reg_sel = 2'd3; sup_mode = 1'b1;
    endtask

    task automatic exp_req(input bit req, input int idx, input string tag);
        item_t it;
        it.cyc = cyc; it.is_reg = 1'b0;
        it.exp = {11'd0, req, (req ? 4'(idx) : svc_idx)};
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_rd(input logic [1:0] sel, input bit sup,
                          input logic [15:0] v, input string tag);
        item_t it;
        reg_sel = sel; sup_mode = sup;
        it.cyc = cyc; it.is_reg = 1'b1; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] sel, input bit sup, input logic [15:0] v);
        reg_sel = sel; sup_mode = sup; reg_we = 1'b1; reg_wdata = v;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        exp_rd(2'd0, 1, 16'h0000, "R1 latch"); exp_req(0, 0, "R1 req"); tick();
        exp_rd(2'd1, 1, 16'h0000, "R1 mask"); tick();
        exp_rd(2'd2, 1, 16'h0000, "R1 pend"); tick();
        // R2 capture of timer and reserved slot; timer masked
        evt_in = 16'h0050; tick();
        exp_rd(2'd0, 1, 16'h0040, "R2 latch capture, reserved dropped");
        exp_req(0, 0, "R4 masked timer stays quiet"); tick();
        // R4 unmask timer
        wr(2'd1, 1, 16'h0040); tick();
        exp_req(1, 6, "R4 unmasked timer requests");
        // R10 user-mode mask write ignored
        wr(2'd1, 0, 16'hFFFF); tick();
        exp_rd(2'd1, 1, 16'h0040, "R10 mask after user write"); tick();
        exp_rd(2'd1, 0, 16'h0000, "R10 user mask read"); tick();
        exp_rd(2'd3, 1, 16'h0000, "R10 none select"); tick();
        // R7 accept timer
        exp_req(1, 6, "R7 request before accept"); svc_ack = 1; tick();
        exp_rd(2'd2, 1, 16'h0040, "R7 pend set"); exp_req(0, 0, "R7 no request"); tick();
        exp_rd(2'd2, 0, 16'h0000, "R10 user pend read"); tick();
        exp_rd(2'd0, 1, 16'h0000, "R7 latch cleared"); tick();
        // R6 nesting: level 9 waits behind pending 6
        wr(2'd1, 1, 16'h0240); tick();
        evt_in = 16'h0200; tick();
        exp_req(0, 0, "R6 level 9 below pending 6"); tick();
        evt_in = 16'h0004; tick();
        exp_req(1, 2, "R4 NMI ignores mask"); svc_ack = 1; tick();
        exp_rd(2'd2, 1, 16'h0044, "R7 nested pend"); exp_req(0, 0, "R6 quiet while nested"); tick();
        svc_ret = 1; tick();
        exp_rd(2'd2, 1, 16'h0040, "R8 innermost retired"); exp_req(0, 0, "R6 still under 6"); tick();
        svc_ret = 1; tick();
        exp_rd(2'd2, 1, 16'h0000, "R8 all retired"); exp_req(1, 9, "R6 level 9 released"); tick();
        // R5 global disable
        gp_dis = 1; gp_ena = 1; tick();
        exp_req(0, 0, "R5 gp disabled, disable wins tie");
        exp_rd(2'd0, 1, 16'h0200, "R5 level 9 stays latched"); tick();
        evt_in = 16'h0040; tick();
        exp_req(1, 6, "R5 timer unaffected"); svc_ack = 1; tick();
        svc_ret = 1; tick();
        gp_ena = 1; tick();
        exp_req(1, 9, "R5 gp re-enabled"); svc_ack = 1; tick();
        exp_rd(2'd2, 1, 16'h0200, "R7 level 9 pending"); svc_ret = 1; tick();
        // R7 accept without request ignored
        exp_req(0, 0, "R7 idle"); svc_ack = 1; tick();
        exp_rd(2'd2, 1, 16'h0000, "R7 stray accept no effect"); tick();
        // R9 latch write rules (mask = 0x0240)
        wr(2'd0, 0, 16'h0FFF); tick();
        exp_rd(2'd0, 1, 16'h0DAF, "R9 masked bits kept"); exp_req(1, 0, "R3 lowest wins"); tick();
        evt_in = 16'h0040; tick();
        wr(2'd0, 1, 16'h0000); tick();
        exp_rd(2'd0, 1, 16'h0040, "R9 bit 6 survives clear"); exp_req(1, 6, "R9 timer requests"); tick();
        svc_ack = 1; tick();
        svc_ret = 1; tick();
        // R11 pending write ignored
        evt_in = 16'h0040; tick();
        svc_ack = 1; tick();
        wr(2'd2, 1, 16'hFFFF); tick();
        exp_rd(2'd2, 1, 16'h0040, "R11 pend unwritable"); svc_ret = 1; tick();
        // R3 exception beats gp level 9
        evt_in = 16'h0208; tick();
        exp_req(1, 3, "R3 exception first"); svc_ack = 1; tick();
        exp_req(0, 0, "R6 level 9 waits for 3"); svc_ret = 1; tick();
        exp_req(1, 9, "R3 level 9 next"); svc_ack = 1; tick();
        svc_ret = 1; tick();
        exp_rd(2'd2, 1, 16'h0000, "R8 final pend"); exp_req(0, 0, "R1 idle end"); tick();
        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule